// File: doc/BRIEF.md
# Block-Access Configuration Register Slave on I2C

This block is an I2C target that holds a small bank of 8-bit configuration registers and exposes them to a bus host through whole-bank block transfers. Register contents leave the block on a flat output vector and steer the rest of the device. The block runs on a fast system clock. It oversamples the bus lines through two-flop synchronisers and a persistence filter, then finds START, STOP and clock edges on the filtered lines. It drives SDA open-drain: its only output is a pull-low enable.

There is no register addressing. A write carries two header bytes that the block acknowledges and discards, and then data bytes that fill register 0, register 1 and upward in strict order. A read returns a byte count first and then every register in ascending order. A STOP may end a write after any whole byte. A repeated START abandons the current transfer and begins address matching again. Registers already written during the abandoned transfer keep their new values.

Top module: `blkreg_i2c_slave`

## Requirements
- R1: After reset, register k holds RST_BASE + k (0x40 + k by default), and SDA is released (`sda_oe` low).
- R2: The block acknowledges only the address byte whose upper seven bits equal DEV_ADDR (0x69, so 0xD2 for a write and 0xD3 for a read). Any other address gets no acknowledge, and the block ignores every bus cycle until the next START. The register outputs stay unchanged.
- R3: In a write (address bit 0 = 0), the two bytes after the address are acknowledged and discarded. Each data byte after them is acknowledged and stored, the first into register 0 and each following one into the next higher register. Bytes are received MSB first.
- R4: A STOP after any whole data byte ends the write, and registers not yet reached keep their values.
- R5: Data bytes beyond the last register (the 8th data byte and later with the default bank of 7) are not acknowledged and change no register.
- R6: In a read (address bit 0 = 1), the block sends NUM_REGS (7) as a count byte, then registers 0 to NUM_REGS-1 in ascending order, MSB first. Beyond the last register it sends 0xFF.
- R7: If the host does not acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R8: A START in the middle of a transfer aborts it and restarts address matching. Registers written earlier in the aborted transfer keep the values they were given.
- R9: The block changes its SDA drive only while SCL is low.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks (3 by default) has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | High to pull SDA low |
| cfg_o | output | NUM_REGS*8 | Register bank, register k in bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: seven registers, address 0x69 and a three-clock line filter. A bank of seven puts both the last-register boundary and the over-length write inside short transfers. The three-clock filter lets the bench place one-clock pulses on either line in the middle of a bit and expect them to vanish. With a bus quarter-period of twelve system clocks, the filter and synchroniser delay stays well inside each phase of SCL. This makes the exact cycle of every acknowledge and data bit predictable.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } link_st_e;

endpackage

// File: rtl/blkreg_line_filt.sv
module blkreg_line_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d      = filt_q;
        filt_d.sync = {filt_q.sync[0], line_i};
        if (filt_q.sync[1] == filt_q.filt) begin
            filt_d.cnt = '0;
        end else if (filt_q.cnt == CW'(FILT_LEN - 1)) begin
            filt_d.filt = filt_q.sync[1];
            filt_d.cnt  = '0;
        end else begin
            filt_d.cnt = filt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= '{sync: 2'b11, filt: 1'b1, cnt: '0};
        end else begin
            filt_q <= filt_d;
        end
    end

    assign line_o = filt_q.filt;

    // R10: the filtered level only ever moves to the synchronised level
    assert_filter_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q.filt) |-> filt_q.filt == $past(filt_q.sync[1]));

endmodule

// File: rtl/blkreg_file.sv
module blkreg_file #(
    parameter int         NUM_REGS = 7,
    parameter int         IDX_W    = 4,
    parameter logic [7:0] RST_BASE = 8'h40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [7:0]            wr_data_i,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    always_comb begin
        for (int k = 0; k < NUM_REGS; k++) begin
            regs_d[k] = regs_q[k];
            if (wr_en_i && wr_idx_i == IDX_W'(k)) begin
                regs_d[k] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                regs_q[k] <= RST_BASE + 8'(k);
            end
        end else begin
            for (int k = 0; k < NUM_REGS; k++) begin
                regs_q[k] <= regs_d[k];
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign regs_o[g*8 +: 8] = regs_q[g];
    end

    // R4: without a write strobe the bank holds its contents
    assert_bank_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/blkreg_link.sv
module blkreg_link
    import blkreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 7,
    parameter int         IDX_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_f,
    input  logic                  sda_f,
    input  logic [NUM_REGS*8-1:0] regs_i,
    output logic                  wr_en_o,
    output logic [IDX_W-1:0]      wr_idx_o,
    output logic [7:0]            wr_data_o,
    output logic                  sda_oe_o
);
    localparam int               HDR_BYTES = 2;
    localparam logic [IDX_W-1:0] IDX_MAX   = IDX_W'(NUM_REGS + HDR_BYTES);
    localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(HDR_BYTES);

    typedef struct packed {
        link_st_e         st;
        logic             addr_ph;
        logic             rnw;
        logic [IDX_W-1:0] idx;
        logic [3:0]       bits;
        logic [7:0]       sh;
        logic             drive;
        logic             scl_p;
        logic             sda_p;
    } link_t;

    link_t link_d, link_q;

    logic       is_start, is_stop, scl_rise, scl_fall;
    logic [7:0] tx_cur;

    assign is_start = link_q.scl_p & scl_f & link_q.sda_p & ~sda_f;
    assign is_stop  = link_q.scl_p & scl_f & ~link_q.sda_p & sda_f;
    assign scl_rise = ~link_q.scl_p & scl_f;
    assign scl_fall = link_q.scl_p & ~scl_f;

    // byte to transmit for the current read index
    always_comb begin
        tx_cur = 8'hFF;
        if (link_q.idx == '0) begin
            tx_cur = 8'(NUM_REGS);
        end
        for (int k = 0; k < NUM_REGS; k++) begin
            if (link_q.idx == IDX_W'(k + 1)) begin
                tx_cur = regs_i[k*8 +: 8];
            end
        end
    end

    always_comb begin
        link_d       = link_q;
        link_d.scl_p = scl_f;
        link_d.sda_p = sda_f;
        wr_en_o      = 1'b0;
        wr_idx_o     = link_q.idx - IDX_FIRST;
        wr_data_o    = link_q.sh;

        if (is_start) begin
            link_d.st      = ST_RX;
            link_d.addr_ph = 1'b1;
            link_d.rnw     = 1'b0;
            link_d.idx     = '0;
            link_d.bits    = '0;
            link_d.drive   = 1'b0;
        end else if (is_stop) begin
            link_d.st    = ST_IDLE;
            link_d.drive = 1'b0;
        end else begin
            unique case (link_q.st)
                ST_RX: begin
                    if (scl_rise && link_q.bits != 4'd8) begin
                        link_d.sh   = {link_q.sh[6:0], sda_f};
                        link_d.bits = link_q.bits + 4'd1;
                    end
                    if (scl_fall && link_q.bits == 4'd8) begin
                        if (link_q.addr_ph) begin
                            if (link_q.sh[7:1] == DEV_ADDR) begin
                                link_d.st      = ST_ACK;
                                link_d.drive   = 1'b1;
                                link_d.rnw     = link_q.sh[0];
                                link_d.addr_ph = 1'b0;
                                link_d.idx     = '0;
                            end else begin
                                link_d.st = ST_IDLE;
                            end
                        end else begin
                            link_d.st    = ST_ACK;
                            link_d.drive = (link_q.idx < IDX_MAX);
                            if (link_q.idx >= IDX_FIRST && link_q.idx < IDX_MAX) begin
                                wr_en_o = 1'b1;
                            end
                            if (link_q.idx != IDX_MAX) begin
                                link_d.idx = link_q.idx + 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        link_d.bits = '0;
                        if (link_q.rnw) begin
                            link_d.st    = ST_TX;
                            link_d.sh    = tx_cur;
                            link_d.drive = ~tx_cur[7];
                            link_d.idx   = link_q.idx + 1'b1;
                        end else begin
                            link_d.st    = ST_RX;
                            link_d.drive = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        link_d.bits = link_q.bits + 4'd1;
                    end
                    if (scl_fall) begin
                        if (link_q.bits == 4'd8) begin
                            link_d.st    = ST_MACK;
                            link_d.drive = 1'b0;
                        end else begin
                            link_d.sh    = {link_q.sh[6:0], 1'b1};
                            link_d.drive = ~link_q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise && sda_f) begin
                        link_d.st = ST_IDLE;
                    end else if (scl_fall) begin
                        link_d.st    = ST_TX;
                        link_d.bits  = '0;
                        link_d.sh    = tx_cur;
                        link_d.drive = ~tx_cur[7];
                        if (link_q.idx != IDX_MAX) begin
                            link_d.idx = link_q.idx + 1'b1;
                        end
                    end
                end
                default: begin
                    link_d.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= '{st: ST_IDLE, addr_ph: 1'b1, rnw: 1'b0, idx: '0, bits: '0,
                        sh: '0, drive: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            link_q <= link_d;
        end
    end

    assign sda_oe_o = link_q.drive;

    // R9: the data drive toggles only while the filtered clock is low
    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_q.drive) |-> !scl_f);

    // R7: an idle link never pulls the data line
    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_q.st == ST_IDLE |-> !link_q.drive);

    // R5: stores never target a register past the bank
    assert_write_in_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> int'(wr_idx_o) < NUM_REGS);

    // R3: every stored byte is acknowledged in the following cycle
    assert_store_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (link_q.st == ST_ACK && link_q.drive));

endmodule

// File: rtl/blkreg_i2c_slave.sv
module blkreg_i2c_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 7,
    parameter int         FILT_LEN = 3,
    parameter logic [7:0] RST_BASE = 8'h40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int IDX_W = $clog2(NUM_REGS + 3);

    logic             scl_f, sda_f;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    blkreg_line_filt #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );

    blkreg_line_filt #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    blkreg_link #(
        .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
    ) u_link (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .regs_i(cfg_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
        .wr_data_o(wr_data), .sda_oe_o(sda_oe)
    );

    blkreg_file #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RST_BASE(RST_BASE)
    ) u_file (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .regs_o(cfg_o)
    );

endmodule

// File: tb/blkreg_i2c_slave_tb.sv
`timescale 1ns/1ps
module blkreg_i2c_slave_tb;
    localparam int NREG = 7;
    localparam int Q    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_o;
    wire  sda_line = sda_h & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int r9_viol = 0;
    int glitch = 0;
    bit done = 1'b0;
    logic [7:0] shadow [NREG];
    logic [7:0] wbuf [16];

    always #2.5 clk = ~clk;

    blkreg_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_o(cfg_o)
    );

    function automatic logic [7:0] dflt(input int k);
        return 8'h40 + 8'(k);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // R9 monitor: drive must not move while SCL is high
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && scl_h && prev_scl && sda_oe != prev_oe) r9_viol++;
        prev_oe  = sda_oe;
        prev_scl = scl_h;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input bit v);
        sda_h = v; tick(Q); scl_h = 1'b1; tick(Q);
        tick(Q / 2);
        if (glitch == 1) begin sda_h = ~v; tick(1); sda_h = v; end
        if (glitch == 2) begin scl_h = 1'b0; tick(1); scl_h = 1'b1; end
        tick(Q / 2);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output bit v);
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        v = sda_line; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output bit acked);
        bit v;
        for (int b = 7; b >= 0; b--) put_bit(d[b]);
        get_bit(v);
        acked = !v;
    endtask

    task automatic get_byte(output logic [7:0] d, input bit ack);
        bit v;
        for (int b = 7; b >= 0; b--) begin get_bit(v); d[b] = v; end
        put_bit(!ack);
    endtask

    task automatic port_check(input string tag);
        for (int k = 0; k < NREG; k++)
            check(cfg_o[k*8 +: 8] == shadow[k], tag, cfg_o[k*8 +: 8], shadow[k]);
    endtask

    // write n data bytes from wbuf; optional closing STOP
    task automatic wr_xfer(input int n, input bit with_stop);
        bit a;
        bus_start();
        put_byte(8'hD2, a); check(a, "R2 write address ack", a, 1);
        put_byte(8'($urandom), a); check(a, "R3 header0 ack", a, 1);
        put_byte(8'($urandom), a); check(a, "R3 header1 ack", a, 1);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], a);
            if (i < NREG) begin
                check(a, "R3 data ack", a, 1);
                shadow[i] = wbuf[i];
            end else begin
                check(!a, "R5 overflow nack", a, 0);
            end
        end
        if (with_stop) bus_stop();
    endtask

    task automatic rd_verify();
        bit a;
        logic [7:0] d;
        bus_start();
        put_byte(8'hD3, a); check(a, "R6 read address ack", a, 1);
        get_byte(d, 1'b1); check(d == 8'(NREG), "R6 count byte", d, NREG);
        for (int k = 0; k < NREG; k++) begin
            get_byte(d, k != NREG - 1);
            check(d == shadow[k], "R6 read data", d, shadow[k]);
        end
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] d;
        void'($urandom(32'd7741));
        for (int k = 0; k < NREG; k++) shadow[k] = dflt(k);
        tick(5); rst_n = 1'b1; tick(5);

        // R1 reset state
        port_check("R1 reset default");
        check(!sda_oe, "R1 sda released", sda_oe, 0);

        // R3 full directed write, then readback
        for (int i = 0; i < NREG; i++) wbuf[i] = 8'hA5 ^ 8'(i * 17);
        wr_xfer(NREG, 1'b1);
        port_check("R3 full write");
        rd_verify();

        // R4 partial write of three bytes
        for (int i = 0; i < 3; i++) wbuf[i] = 8'h11 * 8'(i + 1);
        wr_xfer(3, 1'b1);
        port_check("R4 partial write");

        // R5 over-length write of nine bytes
        for (int i = 0; i < 9; i++) wbuf[i] = 8'hC0 + 8'(i);
        wr_xfer(9, 1'b1);
        port_check("R5 over-length write");

        // R2 foreign addresses, write and read forms
        bus_start();
        put_byte(8'hA4, a); check(!a, "R2 foreign write nack", a, 0);
        put_byte(8'h3C, a); check(!a, "R2 ignored byte nack", a, 0);
        bus_stop();
        bus_start();
        put_byte(8'hD5, a); check(!a, "R2 foreign read nack", a, 0);
        get_bit(a); check(a, "R2 line released", a, 1);
        bus_stop();
        port_check("R2 regs unchanged");

        // R7 host nacks the count byte, slave goes quiet
        bus_start();
        put_byte(8'hD3, a); check(a, "R7 address ack", a, 1);
        get_byte(d, 1'b0); check(d == 8'(NREG), "R7 count byte", d, NREG);
        get_byte(d, 1'b0); check(d == 8'hFF, "R7 released after nack", d, 8'hFF);
        bus_stop();
        port_check("R7 regs unchanged");

        // R8 repeated start after two data bytes
        wbuf[0] = 8'h5A; wbuf[1] = 8'h3D;
        wr_xfer(2, 1'b0);
        rd_verify();
        port_check("R8 abort keeps writes");

        // R10 one-clock pulses on SDA and on SCL in the middle of bits
        for (int i = 0; i < NREG; i++) wbuf[i] = 8'h96 + 8'(i * 3);
        glitch = 1;
        wr_xfer(NREG, 1'b1);
        glitch = 0;
        port_check("R10 sda pulse ignored");
        for (int i = 0; i < NREG; i++) wbuf[i] = 8'h2B ^ 8'(i * 29);
        glitch = 2;
        wr_xfer(NREG, 1'b1);
        glitch = 0;
        port_check("R10 scl pulse ignored");

        // random write lengths, then readback
        for (int r = 0; r < 6; r++) begin
            int n;
            n = int'($urandom % 10);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_xfer(n, 1'b1);
            port_check("R4 random write");
            if (r % 2 == 1) rd_verify();
        end

        check(r9_viol == 0, "R9 drive stable while SCL high", r9_viol, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule